// File: doc/BRIEF.md
# Power Sequence Command Engine

This block walks a table of packed power-sequence commands and carries each one out as transactions on a simple register bus. Software, or a fixed table in ROM, describes how to bring a chip into or out of a power state as a list of entries. The engine fetches them one at a time, starting at index 0, through a synchronous table port. It checks each entry against the current chip cut, fab and host interface, and then performs a masked read, a masked read-modify-write, a masked poll or a timed wait. It stops at the first end entry.

A pulse on `start` launches a sequence. `busy` stays high while the table is being walked. `done` rises when the sequence finishes and holds until the next start. If a poll does not reach its target value in time, the engine abandons the sequence and raises `tmo_err` together with `done`. Microsecond and millisecond timing comes from an internal prescaler whose ratio is a parameter.

Each table entry is 56 bits wide. Bit fields, from MSB to LSB:

| Bits | Field |
|---|---|
| 55:40 | register offset, or the delay count for a delay entry |
| 39:32 | cut mask (bit 0 = test chip, bits 1..7 = cuts A..G) |
| 31:28 | fab mask (bits 0 and 1 = the two supported fabs) |
| 27:24 | interface mask (bit 0 = SDIO, bit 1 = USB, bit 2 = PCI) |
| 23:20 | base selector (MAC = 0, USB = 1, PCIe = 2, SDIO = 3) |
| 19:16 | command |
| 15:8 | bit mask |
| 7:0 | value |

Command codes: read = 0, write = 1, poll = 2, delay = 3, end = 4.

Top module: `pwrseq_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `tmo_err`, `reg_rd`, `reg_wr` and `tbl_rd_en` are all low.
- R2: Entries are fetched in ascending index order starting at 0. The table returns the data for `tbl_idx` one cycle after `tbl_rd_en`. When several writes target one register, the last one in the table wins.
- R3: Apart from end, an entry runs only if three tests all pass: its cut mask ANDed with the one-hot `cur_cut` is non-zero, its fab mask ANDed with `cur_fab` is non-zero, and its interface mask ANDed with `cur_intf` is non-zero. Any other entry is skipped and causes no bus access.
- R4: A write entry (code 1) first reads the register. It then writes back `(old & ~mask) | (value & mask)`.
- R5: A read entry (code 0) issues exactly one bus read and no write.
- R6: A poll entry (code 2) keeps reading the register until `(data & mask) == (value & mask)`, and then moves on to the next entry.
- R7: If a poll has not matched after `POLL_TMO_US` microsecond ticks, the engine stops. `tmo_err` and `done` go high together, later entries do not run, and `tmo_err` holds until the next start.
- R8: A delay entry (code 3) with value bit 0 = 0 waits for offset × `CLK_PER_US` cycles. A table holding only such a delay followed by an end keeps `busy` high for N·`CLK_PER_US` + 5 cycles.
- R9: A delay entry with value bit 0 = 1 counts in milliseconds of `US_PER_MS` microseconds. The same two-entry table keeps `busy` high for N·`US_PER_MS`·`CLK_PER_US` + 5 cycles.
- R10: An end entry (code 4) runs regardless of its masks. It drops `busy` and raises `done`, which then holds, and no later entry runs. A table that starts with an end keeps `busy` high for 2 cycles.
- R11: `start` has no effect while `busy` is high.
- R12: The bus address is `{base, offset}`, 20 bits wide. A request holds its address until `reg_ready` is seen, and `reg_rd` and `reg_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence at table index 0 |
| cur_cut | input | 8 | One-hot current chip cut |
| cur_fab | input | 4 | One-hot current fab |
| cur_intf | input | 4 | One-hot current host interface |
| tbl_rd_en | output | 1 | Table read request |
| tbl_idx | output | IDX_W | Table index being read |
| tbl_data | input | 56 | Entry returned one cycle after the request |
| reg_rd | output | 1 | Register read request, held until ready |
| reg_wr | output | 1 | Register write request, held until ready |
| reg_addr | output | 20 | `{base, offset}` target address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid while `reg_ready` is high |
| reg_ready | input | 1 | Completes the pending request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until the next start |
| tmo_err | output | 1 | Poll timeout, held until the next start |

## Verification
The bench builds the engine with `CLK_PER_US` = 4, `US_PER_MS` = 5, `POLL_TMO_US` = 10 and `IDX_W` = 4. These small values make millisecond waits and poll timeouts only tens of cycles long, so exact cycle counts for both delay units can be checked against a closed-form formula. The small table and register space also make it practical to sweep all 256 write masks and every one-hot combination of cut, fab and interface against a fixed set of entry masks.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;
  localparam int ENTRY_W = 56;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 20;

  localparam logic [3:0] CMD_READ  = 4'd0;
  localparam logic [3:0] CMD_WRITE = 4'd1;
  localparam logic [3:0] CMD_POLL  = 4'd2;
  localparam logic [3:0] CMD_DELAY = 4'd3;
  localparam logic [3:0] CMD_END   = 4'd4;

  typedef struct packed {
    logic [15:0]       offset;
    logic [7:0]        cut_m;
    logic [3:0]        fab_m;
    logic [3:0]        intf_m;
    logic [3:0]        base;
    logic [3:0]        cmd;
    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] value;
  } pwr_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_EXEC, ST_BUS_RD, ST_BUS_WR, ST_DELAY
  } seq_state_e;
endpackage

// File: rtl/pwrseq_tick.sv
`timescale 1ns/1ps
module pwrseq_tick #(
  parameter int CLK_PER_US = 250,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic us_tick,
  output logic ms_tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int MW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

  logic [PW-1:0] pre;
  logic [MW-1:0] ucnt;

  assign us_tick = !clr && (pre == PW'(CLK_PER_US - 1));
  assign ms_tick = us_tick && (ucnt == MW'(US_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre  <= '0;
      ucnt <= '0;
    end else begin
      pre <= us_tick ? '0 : pre + PW'(1);
      if (ms_tick)      ucnt <= '0;
      else if (us_tick) ucnt <= ucnt + MW'(1);
    end
  end

  // After a clear the next microsecond is a full prescaler period away
  assert_clr_restarts_R8: assert property (@(posedge clk) disable iff (rst)
    clr && (CLK_PER_US > 1) |=> !us_tick);
endmodule

// File: rtl/pwrseq_match.sv
`timescale 1ns/1ps
module pwrseq_match (
  input  logic [7:0] cut_m,
  input  logic [3:0] fab_m,
  input  logic [3:0] intf_m,
  input  logic [7:0] cur_cut,
  input  logic [3:0] cur_fab,
  input  logic [3:0] cur_intf,
  output logic       hit
);
  assign hit = (|(cut_m & cur_cut)) && (|(fab_m & cur_fab)) && (|(intf_m & cur_intf));
endmodule

// File: rtl/pwrseq_engine.sv
`timescale 1ns/1ps
module pwrseq_engine
  import pwrseq_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int CLK_PER_US  = 250,
  parameter int US_PER_MS   = 1000,
  parameter int POLL_TMO_US = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         cur_cut,
  input  logic [3:0]         cur_fab,
  input  logic [3:0]         cur_intf,
  output logic               tbl_rd_en,
  output logic [IDX_W-1:0]   tbl_idx,
  input  logic [ENTRY_W-1:0] tbl_data,
  output logic               reg_rd,
  output logic               reg_wr,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  reg_rdata,
  input  logic               reg_ready,
  output logic               busy,
  output logic               done,
  output logic               tmo_err
);
  localparam int PCW = $clog2(POLL_TMO_US + 1);

  seq_state_e        state;
  pwr_entry_t        ent_in;
  logic [3:0]        e_cmd;
  logic [DATA_W-1:0] e_mask, e_val;
  logic [15:0]       dcnt;
  logic [PCW-1:0]    pcnt;
  logic              hit, clr, us_tick, ms_tick, unit_tick, e_ms;
  logic              poll_ok, pcnt_done, go_next;

  assign ent_in = pwr_entry_t'(tbl_data);
  assign clr    = (state == ST_EXEC);

  pwrseq_match u_match (
    .cut_m(ent_in.cut_m), .fab_m(ent_in.fab_m), .intf_m(ent_in.intf_m),
    .cur_cut(cur_cut), .cur_fab(cur_fab), .cur_intf(cur_intf), .hit(hit)
  );

  pwrseq_tick #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .clr(clr), .us_tick(us_tick), .ms_tick(ms_tick)
  );

  assign unit_tick = e_ms ? ms_tick : us_tick;
  assign poll_ok   = ((reg_rdata ^ e_val) & e_mask) == '0;
  assign pcnt_done = (pcnt == PCW'(POLL_TMO_US));

  always_comb begin
    go_next = 1'b0;
    case (state)
      ST_EXEC:   go_next = (ent_in.cmd != CMD_END) && (!hit || ent_in.cmd > CMD_DELAY);
      ST_BUS_RD: go_next = reg_ready && ((e_cmd == CMD_READ) || (e_cmd == CMD_POLL && poll_ok));
      ST_BUS_WR: go_next = reg_ready;
      ST_DELAY:  go_next = (dcnt == '0);
      default:   go_next = 1'b0;
    endcase
  end

  // Poll window counter in microsecond ticks, saturating at the limit
  always_ff @(posedge clk) begin
    if (rst || clr)                 pcnt <= '0;
    else if (us_tick && !pcnt_done) pcnt <= pcnt + PCW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tbl_rd_en <= 1'b0;
      tbl_idx   <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      tmo_err   <= 1'b0;
      e_cmd     <= '0;
      e_mask    <= '0;
      e_val     <= '0;
      e_ms      <= 1'b0;
      dcnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          busy      <= 1'b1;
          done      <= 1'b0;
          tmo_err   <= 1'b0;
          tbl_idx   <= '0;
          tbl_rd_en <= 1'b1;
          state     <= ST_LOAD;
        end
        ST_LOAD: begin
          tbl_rd_en <= 1'b0;
          state     <= ST_EXEC;
        end
        ST_EXEC: begin
          e_cmd  <= ent_in.cmd;
          e_mask <= ent_in.bmask;
          e_val  <= ent_in.value;
          e_ms   <= ent_in.value[0];
          if (ent_in.cmd == CMD_END) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (ent_in.cmd == CMD_DELAY) begin
            dcnt  <= ent_in.offset;
            state <= ST_DELAY;
          end else begin
            reg_rd   <= 1'b1;
            reg_addr <= {ent_in.base, ent_in.offset};
            state    <= ST_BUS_RD;
          end
        end
        ST_BUS_RD: if (reg_ready) begin
          if (e_cmd == CMD_WRITE) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b1;
            reg_wdata <= (reg_rdata & ~e_mask) | (e_val & e_mask);
            state     <= ST_BUS_WR;
          end else if (e_cmd == CMD_POLL && !poll_ok) begin
            if (pcnt_done) begin
              reg_rd  <= 1'b0;
              busy    <= 1'b0;
              done    <= 1'b1;
              tmo_err <= 1'b1;
              state   <= ST_IDLE;
            end
          end else begin
            reg_rd <= 1'b0;
          end
        end
        ST_BUS_WR: if (reg_ready) reg_wr <= 1'b0;
        ST_DELAY:  if (dcnt != '0 && unit_tick) dcnt <= dcnt - 16'd1;
        default:   state <= ST_IDLE;
      endcase
      if (go_next) begin
        reg_rd    <= 1'b0;
        tbl_idx   <= tbl_idx + IDX_W'(1);
        tbl_rd_en <= 1'b1;
        state     <= ST_LOAD;
      end
    end
  end

  assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr));
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    reg_rd && !reg_ready |=> reg_rd && $stable(reg_addr));
  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    reg_wr && !reg_ready |=> reg_wr && $stable(reg_wdata));
  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> done);
  assert_no_bus_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !reg_rd && !reg_wr);
endmodule

// File: tb/pwrseq_engine_tb_top.sv
`timescale 1ns/1ps
module pwrseq_engine_tb_top;
  localparam int IDX_W = 4, CPU = 4, UPM = 5, TMO = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] cur_cut = 8'h02;
  logic [3:0] cur_fab = 4'h1, cur_intf = 4'h1;
  logic tbl_rd_en, reg_rd, reg_wr, reg_ready, busy, done, tmo_err;
  logic [IDX_W-1:0] tbl_idx;
  logic [55:0] tbl_q;
  logic [19:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [55:0] tbl [16];
  logic [7:0] regs [64];
  int rd_cnt, wr_cnt, n_chk, n_fail;
  logic set_en = 1'b0, clr_cnt = 1'b0;
  logic [5:0] set_idx;
  logic [7:0] set_val;
  logic [5:0] ridx;

  always #2 clk = ~clk;

  pwrseq_engine #(.IDX_W(IDX_W), .CLK_PER_US(CPU), .US_PER_MS(UPM), .POLL_TMO_US(TMO)) dut_i (
    .clk(clk), .rst(rst), .start(start), .cur_cut(cur_cut), .cur_fab(cur_fab),
    .cur_intf(cur_intf), .tbl_rd_en(tbl_rd_en), .tbl_idx(tbl_idx), .tbl_data(tbl_q),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready), .busy(busy), .done(done), .tmo_err(tmo_err));

  // Bench models: table ROM with one-cycle latency and a tiny register space.
  // Address {base[1:0], offset[3:0]} indexes it; index 63 returns the read count.
  assign ridx      = {reg_addr[17:16], reg_addr[3:0]};
  assign reg_ready = reg_rd | reg_wr;
  assign reg_rdata = (ridx == 6'd63) ? rd_cnt[7:0] : regs[ridx];

  always @(posedge clk) if (tbl_rd_en) tbl_q <= tbl[tbl_idx];

  always @(posedge clk) begin
    if (set_en) regs[set_idx] <= set_val;
    if (reg_wr && reg_ready) regs[ridx] <= reg_wdata;
    if (clr_cnt) begin
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else begin
      if (reg_rd && reg_ready) rd_cnt <= rd_cnt + 1;
      if (reg_wr && reg_ready) wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [55:0] mk(input logic [15:0] off, input logic [7:0] cm,
      input logic [3:0] fm, input logic [3:0] im, input logic [3:0] base,
      input logic [3:0] cmd, input logic [7:0] msk, input logic [7:0] val);
    return {off, cm, fm, im, base, cmd, msk, val};
  endfunction

  function automatic logic [55:0] e_all(input logic [15:0] off, input logic [3:0] base,
      input logic [3:0] cmd, input logic [7:0] msk, input logic [7:0] val);
    return mk(off, 8'hFF, 4'hF, 4'hF, base, cmd, msk, val);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 16; i++) tbl[i] = e_all(16'h0, 4'h0, 4'd4, 8'h0, 8'h0);
  endtask

  task automatic preset(input int idx, input logic [7:0] v);
    set_idx = idx[5:0];
    set_val = v;
    set_en  = 1'b1;
    @(negedge clk);
    set_en  = 1'b0;
  endtask

  task automatic run(input int restart_at, output int cyc);
    clr_cnt = 1'b1;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    clr_cnt = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (busy) cyc++;
      start = (cyc == restart_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(150000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 64; i++) regs[i] = 8'h00;
    clear_tbl();
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 0);
    chk("R1 outputs in reset", {26'd0, done, tmo_err, reg_rd, reg_wr, tbl_rd_en, 1'b0}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {26'd0, busy, done, tmo_err, reg_rd, reg_wr, tbl_rd_en}, 0);

    // R2: three writes in order, the last wins
    clear_tbl();
    tbl[0] = e_all(16'h2, 4'h0, 4'd1, 8'hFF, 8'h11);
    tbl[1] = e_all(16'h2, 4'h0, 4'd1, 8'hFF, 8'h22);
    tbl[2] = e_all(16'h2, 4'h0, 4'd1, 8'hFF, 8'h33);
    run(-1, cyc);
    chk("R2 last write wins", {24'd0, regs[2]}, 32'h33);
    chk("R2 write count", wr_cnt, 3);

    // R4: sweep of all write masks
    for (int m = 0; m < 256; m++) begin
      clear_tbl();
      tbl[0] = e_all(16'h4, 4'h0, 4'd1, m[7:0], 8'h5A);
      preset(4, 8'h96);
      run(-1, cyc);
      chk("R4 masked write", {24'd0, regs[4]}, {24'd0, (8'h96 & ~m[7:0]) | (8'h5A & m[7:0])});
    end

    // R3: filter sweep over one-hot cut/fab/interface
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 2; f++)
        for (int k = 0; k < 3; k++) begin
          logic expect_hit;
          cur_cut  = 8'(1 << c);
          cur_fab  = 4'(1 << f);
          cur_intf = 4'(1 << k);
          expect_hit = ((8'hA5 >> c) & 1) && (f == 1) && ((4'h5 >> k) & 1);
          clear_tbl();
          tbl[0] = mk(16'h1, 8'hA5, 4'h2, 4'h5, 4'h0, 4'd1, 8'hFF, 8'hC3);
          preset(1, 8'h00);
          run(-1, cyc);
          chk("R3 filter result", {24'd0, regs[1]}, expect_hit ? 32'hC3 : 32'h0);
          chk("R3 bus reads", rd_cnt, expect_hit ? 1 : 0);
        end
    cur_cut = 8'h02; cur_fab = 4'h1; cur_intf = 4'h1;

    // R5: read only
    clear_tbl();
    tbl[0] = e_all(16'h5, 4'h0, 4'd0, 8'hFF, 8'h00);
    preset(5, 8'h5A);
    run(-1, cyc);
    chk("R5 one read", rd_cnt, 1);
    chk("R5 no write", wr_cnt, 0);
    chk("R5 reg unchanged", {24'd0, regs[5]}, 32'h5A);

    // R12: address composed of base and offset
    clear_tbl();
    tbl[0] = e_all(16'h5, 4'h2, 4'd1, 8'hFF, 8'h37);
    run(-1, cyc);
    chk("R12 base 2 target", {24'd0, regs[37]}, 32'h37);
    chk("R12 base 0 untouched", {24'd0, regs[5]}, 32'h5A);

    // R6: poll the read counter until low nibble equals 3
    clear_tbl();
    tbl[0] = e_all(16'hF, 4'h3, 4'd2, 8'h0F, 8'hF3);
    tbl[1] = e_all(16'h6, 4'h0, 4'd1, 8'hFF, 8'h66);
    run(-1, cyc);
    chk("R6 poll read count", rd_cnt, 5);
    chk("R6 no timeout", {31'd0, tmo_err}, 0);
    chk("R6 next entry ran", {24'd0, regs[6]}, 32'h66);

    // R7: poll never matches
    clear_tbl();
    preset(7, 8'h00);
    preset(8, 8'h00);
    tbl[0] = e_all(16'h7, 4'h0, 4'd2, 8'h01, 8'h01);
    tbl[1] = e_all(16'h8, 4'h0, 4'd1, 8'hFF, 8'h88);
    run(-1, cyc);
    chk("R7 timeout flag", {30'd0, tmo_err, done}, 3);
    chk("R7 window length", {31'd0, cyc >= TMO * CPU}, 1);
    chk("R7 later entry skipped", {24'd0, regs[8]}, 0);
    repeat (4) @(negedge clk);
    chk("R7 flag sticky", {30'd0, tmo_err, busy}, 2);

    // R8: microsecond delays
    for (int n = 0; n < 4; n++) begin
      clear_tbl();
      tbl[0] = e_all(16'(n), 4'h0, 4'd3, 8'h00, 8'h00);
      run(-1, cyc);
      chk("R8 us delay cycles", cyc, n * CPU + 5);
      chk("R8 no error", {31'd0, tmo_err}, 0);
    end

    // R9: millisecond delays
    for (int n = 1; n < 3; n++) begin
      clear_tbl();
      tbl[0] = e_all(16'(n), 4'h0, 4'd3, 8'h00, 8'h01);
      run(-1, cyc);
      chk("R9 ms delay cycles", cyc, n * UPM * CPU + 5);
    end

    // R11: start pulsed mid-sequence changes nothing
    clear_tbl();
    tbl[0] = e_all(16'd3, 4'h0, 4'd3, 8'h00, 8'h00);
    run(5, cyc);
    chk("R11 start ignored", cyc, 3 * CPU + 5);

    // R10: end first, with masks that match nothing
    clear_tbl();
    preset(9, 8'h00);
    tbl[0] = mk(16'h0, 8'h00, 4'h0, 4'h0, 4'h0, 4'd4, 8'h00, 8'h00);
    tbl[1] = e_all(16'h9, 4'h0, 4'd1, 8'hFF, 8'h99);
    run(-1, cyc);
    chk("R10 end length", cyc, 2);
    chk("R10 no bus access", rd_cnt + wr_cnt, 0);
    repeat (5) @(negedge clk);
    chk("R10 done holds", {30'd0, done, busy}, 2);
    chk("R10 later entry not run", {24'd0, regs[9]}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule